// File: doc/BRIEF.md
# Ping-Pong Linked DMA Channel

This block is one event-driven DMA channel. It fills two memory buffers in alternation from a fixed source word. Each trigger event reads one 32-bit word from the source, using a one-cycle read strobe with the data captured on the same edge. It then writes that word to memory through a request/acknowledge port. After each write the destination address advances by one word and the remaining element count drops by one.

The channel has two parameter sets. Each set holds a destination base, an element count and a link to a set. When the active count runs out, the channel reloads its working state from the linked set, so the next event lands at the start of the other buffer. Software never has to re-arm the channel. At every buffer end the channel sets a sticky interrupt-pending bit and records which set has just been filled, so software can work on that buffer while the other one fills.

Events that arrive while a write is still waiting, or while the channel is disabled, are held one deep. A further event while one is already held sets a sticky missed-event flag. While the channel is disabled, its working state stays parked at the start of set 0.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, set 0 has base 0x8000_0000, set 1 has base 0x8000_1000, both counts are 1008 and set 0 links to set 1 and set 1 to set 0. Also after reset, mem_req, irq_pend, missed and last_buf are all 0.
- R2: An event accepted while the channel is enabled and idle pulses src_rd for one cycle and captures src_data at that edge. From the next cycle on, mem_req is held high with the captured word on mem_data, and mem_addr and mem_data do not change until mem_ack is seen.
- R3: Within a buffer, each acknowledged write raises the destination address by 4 bytes.
- R4: The acknowledged write that uses up the active count reloads base, count and link from the set named by the active link field. The next write goes to that set's base. A count of 0 behaves as 1.
- R5: Each buffer end sets irq_pend. irq_pend stays set until a cycle with irq_clr high. If a buffer end and irq_clr fall in the same cycle, irq_pend ends up set.
- R6: irq equals irq_pend gated by irq_en. irq_en does not change irq_pend.
- R7: At each buffer end, last_buf takes the index (0 or 1) of the set that was just completed.
- R8: An event that arrives while a write is in flight, or while chan_en is low, is held one deep. It is serviced once the channel is enabled and idle.
- R9: An event that arrives while one is already held sets missed. missed stays set until evt_clr, and evt_clr also drops any held event.
- R10: While chan_en is low, no source read starts. When the channel is enabled again, it starts at the base and count of set 0.
- R11: A configuration write with cfg_we high writes the set chosen by cfg_sel. cfg_field 0 writes the base (the two low bits are forced to 0), 1 writes the count and 2 writes the link (bit 0 of cfg_wdata). A write never changes the active buffer until its next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable |
| irq_en | input | 1 | Interrupt output enable |
| evt | input | 1 | Trigger event, one pulse per element |
| evt_clr | input | 1 | Clears the held event and the missed flag |
| irq_clr | input | 1 | Clears irq_pend |
| cfg_we | input | 1 | Parameter-set write strobe |
| cfg_sel | input | 1 | Parameter set to write |
| cfg_field | input | 2 | 0 base, 1 count, 2 link |
| cfg_wdata | input | 32 | Configuration write data |
| src_rd | output | 1 | Source read strobe |
| src_data | input | 32 | Source word |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| irq | output | 1 | Gated interrupt |
| irq_pend | output | 1 | Sticky buffer-end pending bit |
| last_buf | output | 1 | Index of the last completed set |
| missed | output | 1 | Sticky missed-event flag |

## Verification
A wrong working address or count shows up on mem_addr at the very next acknowledged write. A broken reload shows up at the first write after a buffer end, which lands somewhere other than the linked base. A fault in the event latch shows as a missing or extra write within a few cycles of releasing the memory stall, or as a missed flag that does not match the number of events held back. A fault in the interrupt state shows on irq_pend and last_buf in the cycle after a buffer end or a clear.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
   typedef enum logic [1:0] {
      FLD_BASE  = 2'd0,
      FLD_COUNT = 2'd1,
      FLD_LINK  = 2'd2
   } cfg_field_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_WRITE = 1'b1
   } xfer_st_e;
endpackage

// File: rtl/pp_dma_params.sv
module pp_dma_params #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int DEF_CNT = 1008,
   parameter logic [ADDR_W-1:0] BASE0 = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] BASE1 = 32'h8000_1000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic                       cfg_sel,
   input  logic [1:0]                 cfg_field,
   input  logic [ADDR_W-1:0]          cfg_wdata,
   output logic [1:0][ADDR_W-1:0]     set_base,
   output logic [1:0][CNT_W-1:0]      set_cnt,
   output logic [1:0]                 set_link
);
   import pp_dma_pkg::*;

   localparam int ALIGN_W = $clog2(DATA_W / 8);

   for (genvar s = 0; s < 2; s++) begin : g_set
      localparam logic [ADDR_W-1:0] RST_BASE = (s == 0) ? BASE0 : BASE1;
      logic [ADDR_W-1:0] base_q;
      logic [CNT_W-1:0]  cnt_q;
      logic              link_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= RST_BASE;
            cnt_q  <= CNT_W'(DEF_CNT);
            link_q <= (s == 0);
         end else if (cfg_we && (cfg_sel == 1'(s))) begin
            case (cfg_field)
               FLD_BASE:  base_q <= {cfg_wdata[ADDR_W-1:ALIGN_W], ALIGN_W'(0)};
               FLD_COUNT: cnt_q  <= cfg_wdata[CNT_W-1:0];
               FLD_LINK:  link_q <= cfg_wdata[0];
               default:   ;
            endcase
         end
      end

      assign set_base[s] = base_q;
      assign set_cnt[s]  = cnt_q;
      assign set_link[s] = link_q;
   end
endmodule

// File: rtl/pp_dma_evq.sv
module pp_dma_evq (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic evt_clr,
   input  logic can_start,
   output logic start,
   output logic missed
);
   logic pend_q;
   logic miss_q;

   assign start  = can_start && !evt_clr && (evt || pend_q);
   assign missed = miss_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         miss_q <= 1'b0;
      end else if (evt_clr) begin
         pend_q <= 1'b0;
         miss_q <= 1'b0;
      end else if (start) begin
         pend_q <= pend_q && evt;
      end else if (evt) begin
         if (pend_q) miss_q <= 1'b1;
         pend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pp_dma_xfer.sv
module pp_dma_xfer #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int DEF_CNT = 1008,
   parameter logic [ADDR_W-1:0] BASE0 = 32'h8000_0000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   chan_en,
   input  logic                   start,
   input  logic [1:0][ADDR_W-1:0] set_base,
   input  logic [1:0][CNT_W-1:0]  set_cnt,
   input  logic [1:0]             set_link,
   input  logic [DATA_W-1:0]      src_data,
   input  logic                   mem_ack,
   output logic                   idle,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [DATA_W-1:0]      mem_data,
   output logic                   buf_done,
   output logic                   done_idx
);
   import pp_dma_pkg::*;

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

   xfer_st_e          st_q;
   logic              idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [DATA_W-1:0] data_q;
   logic              last_elem;
   logic              nxt_idx;

   assign idle      = (st_q == ST_IDLE);
   assign mem_req   = (st_q == ST_WRITE);
   assign mem_addr  = addr_q;
   assign mem_data  = data_q;
   assign last_elem = (left_q <= CNT_W'(1));
   assign buf_done  = mem_req && mem_ack && last_elem;
   assign done_idx  = idx_q;
   assign nxt_idx   = set_link[idx_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= 1'b0;
         addr_q <= BASE0;
         left_q <= CNT_W'(DEF_CNT);
         data_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  data_q <= src_data;
                  st_q   <= ST_WRITE;
               end else if (!chan_en) begin
                  idx_q  <= 1'b0;
                  addr_q <= set_base[0];
                  left_q <= set_cnt[0];
               end
            end
            ST_WRITE: begin
               if (mem_ack) begin
                  st_q <= ST_IDLE;
                  if (last_elem) begin
                     idx_q  <= nxt_idx;
                     addr_q <= set_base[nxt_idx];
                     left_q <= set_cnt[nxt_idx];
                  end else begin
                     addr_q <= addr_q + STEP;
                     left_q <= left_q - CNT_W'(1);
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int DEF_CNT = 1008,
   parameter logic [ADDR_W-1:0] BASE0 = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] BASE1 = 32'h8000_1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              irq_en,
   input  logic              evt,
   input  logic              evt_clr,
   input  logic              irq_clr,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [1:0]        cfg_field,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic              src_rd,
   input  logic [DATA_W-1:0] src_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   input  logic              mem_ack,
   output logic              irq,
   output logic              irq_pend,
   output logic              last_buf,
   output logic              missed
);
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must be a whole number of bytes, at least 16");
   end
   if (CNT_W < 1 || CNT_W > ADDR_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 1..ADDR_W");
   end
   if (DEF_CNT < 1 || DEF_CNT >= (64'd1 << CNT_W)) begin : g_bad_def_cnt
      $error("DEF_CNT must fit CNT_W and be nonzero");
   end

   logic [1:0][ADDR_W-1:0] set_base;
   logic [1:0][CNT_W-1:0]  set_cnt;
   logic [1:0]             set_link;
   logic                   idle;
   logic                   start;
   logic                   buf_done;
   logic                   done_idx;
   logic                   pend_q;
   logic                   last_q;

   pp_dma_params #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .DEF_CNT(DEF_CNT), .BASE0(BASE0), .BASE1(BASE1)
   ) u_params (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
      .set_base(set_base), .set_cnt(set_cnt), .set_link(set_link)
   );

   pp_dma_evq u_evq (
      .clk(clk), .rst_n(rst_n), .evt(evt), .evt_clr(evt_clr),
      .can_start(chan_en && idle), .start(start), .missed(missed)
   );

   pp_dma_xfer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .DEF_CNT(DEF_CNT), .BASE0(BASE0)
   ) u_xfer (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start),
      .set_base(set_base), .set_cnt(set_cnt), .set_link(set_link),
      .src_data(src_data), .mem_ack(mem_ack), .idle(idle),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
      .buf_done(buf_done), .done_idx(done_idx)
   );

   assign src_rd   = start;
   assign irq_pend = pend_q;
   assign last_buf = last_q;
   assign irq      = pend_q && irq_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         last_q <= 1'b0;
      end else if (buf_done) begin
         pend_q <= 1'b1;
         last_q <= done_idx;
      end else if (irq_clr) begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chan_en,
   input logic              src_rd,
   input logic              mem_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_data,
   input logic              irq_pend,
   input logic              irq_clr,
   input logic              missed,
   input logic              evt_clr
);
   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_data));

   assert_rd_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd |=> mem_req);

   assert_no_rd_during_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !src_rd);

   assert_no_rd_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd |-> chan_en);

   assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pend && !irq_clr |=> irq_pend);

   assert_miss_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      missed && !evt_clr |=> missed);
endmodule

bind pp_dma_chan pp_dma_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .src_rd(src_rd),
   .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
   .mem_data(mem_data), .irq_pend(irq_pend), .irq_clr(irq_clr),
   .missed(missed), .evt_clr(evt_clr)
);

// File: tb/pp_dma_chan_tb.sv
module pp_dma_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0, irq_en = 1'b0, evt = 1'b0, evt_clr = 1'b0, irq_clr = 1'b0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [1:0]  cfg_field = 2'd0;
   logic [31:0] cfg_wdata = '0;
   logic        src_rd;
   logic [31:0] src_data = 32'h1234_5678;
   logic        mem_req;
   logic [31:0] mem_addr, mem_data;
   logic        mem_ack = 1'b0;
   logic        irq, irq_pend, last_buf, missed;

   pp_dma_chan u_dut (.*);

   always #10 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   logic [31:0] m_base [2];
   int          m_cnt  [2];
   logic        m_link [2];
   logic        m_idx, m_pend, m_last;
   logic [31:0] m_addr, exp_data, last_wr;
   int          m_left, n_wr = 0, wait_cnt = 0;
   logic        stall = 1'b0;
   logic        ack_tk = 0, rd_tk = 0, clr_tk = 0;
   logic [31:0] rd_val;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] next_addr(input logic [31:0] a);
      return a + 32'd4;
   endfunction

   task automatic model_park();
      m_idx = 0; m_addr = m_base[0]; m_left = m_cnt[0];
   endtask

   always @(posedge clk) begin
      ack_tk <= mem_ack;
      rd_tk  <= src_rd;
      rd_val <= src_data;
      clr_tk <= irq_clr;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_tk) begin
            exp_data = rd_val;
            src_data = $urandom;
         end
         if (clr_tk) m_pend = 0;
         if (ack_tk) begin
            mem_ack = 1'b0;
            n_wr++;
            if (m_left <= 1) begin
               m_pend = 1; m_last = m_idx;
               m_idx = m_link[m_idx]; m_addr = m_base[m_idx]; m_left = m_cnt[m_idx];
               check(last_buf == m_last, "R7 last_buf", 32'(last_buf), 32'(m_last));
            end else begin
               m_addr = next_addr(m_addr); m_left--;
            end
         end else if (mem_req && !stall) begin
            if (wait_cnt == 0) begin
               check(mem_addr == m_addr, "R3/R4 address", mem_addr, m_addr);
               check(mem_data == exp_data, "R2 data", mem_data, exp_data);
               last_wr = mem_addr;
               mem_ack = 1'b1;
               wait_cnt = $urandom % 4;
            end else wait_cnt--;
         end
         check(irq_pend == m_pend, "R5 irq_pend", 32'(irq_pend), 32'(m_pend));
         check(irq == (m_pend & irq_en), "R6 irq", 32'(irq), 32'(m_pend & irq_en));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fire();
      @(negedge clk) evt = 1'b1;
      @(negedge clk) evt = 1'b0;
   endtask

   task automatic drain();
      cyc(1);
      while (mem_req) @(negedge clk);
   endtask

   task automatic cfg(input logic s, input logic [1:0] f, input logic [31:0] d);
      @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_field = f; cfg_wdata = d;
      @(negedge clk); cfg_we = 0;
      if (f == 0) m_base[s] = d; else if (f == 1) m_cnt[s] = d; else m_link[s] = d[0];
   endtask

   task automatic set_stall(input logic v);
      @(posedge clk); #2 stall = v;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      int n0;
      void'($urandom(32'h5eed));
      m_base[0] = 32'h8000_0000; m_base[1] = 32'h8000_1000;
      m_cnt[0] = 1008; m_cnt[1] = 1008; m_link[0] = 1; m_link[1] = 0;
      m_pend = 0; m_last = 0; model_park();
      cyc(3); rst_n = 1'b1; cyc(1);
      // R1 reset state
      check(!mem_req && !src_rd, "R1 idle after reset", 32'(mem_req), 0);
      check(!irq_pend && !missed && !last_buf, "R1 flags after reset",
            {irq_pend, missed, last_buf}, 0);

      // R1/R4 default buffers, irq masked
      chan_en = 1;
      for (int i = 0; i < 1008; i++) begin fire(); drain(); end
      check(last_wr == 32'h8000_0FBC, "R1 default end address", last_wr, 32'h8000_0FBC);
      check(irq_pend && !irq, "R6 masked pend", {irq_pend, irq}, 2'b10);
      fire(); drain();
      check(last_wr == 32'h8000_1000, "R4 swap to second buffer", last_wr, 32'h8000_1000);
      @(negedge clk) irq_clr = 1; @(negedge clk) irq_clr = 0; cyc(1);
      check(!irq_pend, "R5 cleared", 32'(irq_pend), 0);

      // R11 reprogram while disabled, R10 parks at set 0
      chan_en = 0; irq_en = 1;
      cfg(0, 2'd0, 32'h8000_4000); cfg(0, 2'd1, 5); cfg(0, 2'd2, 1);
      cfg(1, 2'd0, 32'h8000_6004); cfg(1, 2'd1, 3); cfg(1, 2'd2, 0);
      cyc(2); model_park(); chan_en = 1;
      for (int i = 0; i < 5; i++) begin fire(); drain(); end
      check(last_wr == 32'h8000_4010, "R3 fifth word", last_wr, 32'h8000_4010);
      check(irq && last_buf == 0, "R6/R7 after set 0", {irq, last_buf}, 2'b10);
      for (int i = 0; i < 3; i++) begin fire(); drain(); end
      check(last_wr == 32'h8000_600C, "R4 set 1 end", last_wr, 32'h8000_600C);
      check(last_buf == 1, "R7 set 1 done", 32'(last_buf), 1);
      fire(); drain();
      check(last_wr == 32'h8000_4000, "R4 back to set 0", last_wr, 32'h8000_4000);

      // R11 write does not disturb active buffer
      cfg(0, 2'd0, 32'h8000_8003);
      m_base[0] = 32'h8000_8000;
      for (int i = 0; i < 4; i++) begin fire(); drain(); end
      check(last_wr == 32'h8000_4010, "R11 active kept", last_wr, 32'h8000_4010);
      for (int i = 0; i < 4; i++) begin fire(); drain(); end
      check(last_wr == 32'h8000_8000, "R11 new base on reload", last_wr, 32'h8000_8000);

      // R8/R9 latch and miss
      set_stall(1);
      fire(); cyc(1); fire(); cyc(1);
      check(!missed, "R8 one held event", 32'(missed), 0);
      fire(); cyc(1);
      check(missed, "R9 missed set", 32'(missed), 1);
      n0 = n_wr;
      set_stall(0); cyc(30);
      check(n_wr - n0 == 2, "R8 held event serviced", n_wr - n0, 2);
      @(negedge clk) evt_clr = 1; @(negedge clk) evt_clr = 0; cyc(1);
      check(!missed, "R9 evt_clr", 32'(missed), 0);

      // R10 disabled latches; R9 clear drops held event
      chan_en = 0; n0 = n_wr;
      fire(); cyc(10);
      check(n_wr == n0 && !mem_req, "R10 no transfer while disabled", n_wr - n0, 0);
      model_park(); chan_en = 1; cyc(10);
      check(n_wr - n0 == 1, "R8 held event after enable", n_wr - n0, 1);
      check(last_wr == 32'h8000_8000, "R10 restart at set 0", last_wr, 32'h8000_8000);
      chan_en = 0; fire(); @(negedge clk) evt_clr = 1; @(negedge clk) evt_clr = 0;
      model_park(); n0 = n_wr; chan_en = 1; cyc(10);
      check(n_wr == n0, "R9 clear drops held event", n_wr - n0, 0);

      // random traffic
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         evt = ($urandom % 4 == 0);
         irq_clr = ($urandom % 16 == 0);
         if ($urandom % 64 == 0) irq_en = ~irq_en;
      end
      @(negedge clk) begin evt = 0; irq_clr = 0; end
      cyc(30);
      check(!mem_req, "R2 drained", 32'(mem_req), 0);
      report();
   end
endmodule